// File: doc/BRIEF.md
# Speculative Transaction State Tracker

This block holds the per-core speculative state of a best-effort hardware transactional memory. While a transaction is open it remembers which cache lines the core has loaded, using one flag per line, and it keeps every transactional store in a small address/data buffer instead of letting it reach the cache. Loads that hit the buffer return the buffered value. Coherence requests from other cores are compared against the flags and the buffered addresses. The combined effect is a two-phase locking scheme: the flags act as read locks and the buffered addresses act as write locks, and all of them are released together at commit or abort.

The core opens a transaction with a begin command that carries a fail address. The block then asks for a register snapshot. On commit, every buffered entry is presented on a wide drain port for exactly one cycle so that the cache array can absorb all of them in one action. On any abort, whether from a conflict, a buffer overflow, the eviction of a flagged line or an explicit request, the block discards the speculative state. It pulses a restore request, holds the fail address on its redirect output, and reports a cause code. Each address is one cache line wide.

Top module: `txn_spec_state`

## Requirements
- R1: When no transaction is open, `tx_begin` sets `tx_active` at the next edge, pulses `ckpt_snap` for one cycle and latches `tx_fail_pc` onto `redirect_pc`. A begin issued while a transaction is open is ignored: no snapshot pulse, `redirect_pc` unchanged, and the transaction continues.
- R2: A load issued inside a transaction flags its line as read from the next edge onward. Loads outside a transaction flag nothing.
- R3: A transactional store goes into the buffer and never appears on the drain port before commit. A load to a buffered address returns the buffered value on `ld_data` in the same cycle. Any other load returns `ld_cache_data`.
- R4: A store to an address already buffered overwrites that entry and allocates no new one. This holds even when the buffer is full. A store to a new address while all DEPTH entries (default 8) are used aborts with cause 3 and does not stall.
- R5: A remote write snoop (`snp_is_write`=1) whose address matches a read-flagged line or a buffered address aborts the transaction with cause 2.
- R6: A remote read snoop (`snp_is_write`=0) aborts with cause 1 only if its address matches a buffered address. A match against a read flag alone has no effect.
- R7: Evicting a read-flagged line aborts with cause 4. Evicting an unflagged line has no effect.
- R8: `tx_abort` during a transaction aborts with cause 5.
- R9: `tx_commit` closes the transaction at the next edge. In that same cycle `drain_valid` shows one bit per used entry, slots filled in allocation order from slot 0, with the entries' addresses on `drain_addr` (slot k at bits k*AW) and their data on `drain_data` (slot k at bits k*DW). The port then returns to zero. Afterwards the read flags and the buffer are empty.
- R10: An abort pulses `tx_aborted` for one cycle at the next edge, clears `tx_active` and keeps `redirect_pc` at the latched fail address. It drains nothing, discards every buffered value and clears every read flag.
- R11: When several abort reasons occur in one cycle, the cause is chosen by priority: remote write (2), then remote read (1), then eviction (4), then overflow (3), then explicit (5). Any abort reason beats a commit in the same cycle.
- R12: `abort_cause` is 0 after reset. It holds the last abort's code until the next accepted begin, which returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin | input | 1 | Open a transaction |
| tx_fail_pc | input | PCW | Fail address to resume at on abort |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort | input | 1 | Explicit abort request |
| ld_valid | input | 1 | Local load this cycle |
| ld_addr | input | AW | Load line address |
| ld_cache_data | input | DW | Value read from the cache for the load |
| ld_data | output | DW | Load result, forwarded from the buffer on a hit |
| st_valid | input | 1 | Local transactional store this cycle |
| st_addr | input | AW | Store line address |
| st_data | input | DW | Store value |
| snp_valid | input | 1 | Incoming coherence request |
| snp_is_write | input | 1 | 1 = remote write request, 0 = remote read request |
| snp_addr | input | AW | Snooped line address |
| evict_valid | input | 1 | A line leaves the local cache |
| evict_addr | input | AW | Evicted line address |
| tx_active | output | 1 | A transaction is open |
| ckpt_snap | output | 1 | Register snapshot request (one cycle) |
| tx_aborted | output | 1 | Abort: restore registers and redirect (one cycle) |
| abort_cause | output | 3 | 0 none, 1 remote read, 2 remote write, 3 overflow, 4 eviction, 5 explicit |
| redirect_pc | output | PCW | Fail address latched at begin |
| drain_valid | output | DEPTH | Per-slot write enables for the commit drain |
| drain_addr | output | DEPTH*AW | Per-slot drain addresses |
| drain_data | output | DEPTH*DW | Per-slot drain data |

## Verification
The lock behaviour is tried with snoops of both kinds against four kinds of line: flagged only, buffered only, flagged and buffered, and untouched. This separates the read-lock path from the write-lock path and shows that a remote read meets only the write locks. The buffer is driven with repeated and distinct addresses up to and past capacity. That tells an in-place overwrite apart from a fresh allocation, and shows that a repeated store into a full buffer survives while a new address overflows. Stacked abort reasons in one cycle, and commit together with abort, pin down the cause priority. Transactions that follow an abort or a commit confirm that the old flags and entries were dropped.

// File: rtl/txn_pkg.sv
// Package: shared types for the speculative transaction state tracker.
// Assumes: cause codes are observed by software-visible logic outside,
// so their values are fixed.
package txn_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_RREAD  = 3'd1,
        CAUSE_RWRITE = 3'd2,
        CAUSE_OVF    = 3'd3,
        CAUSE_EVICT  = 3'd4,
        CAUSE_SW     = 3'd5
    } abort_cause_e;

endpackage

// File: rtl/txn_rdset.sv
// Module: txn_rdset
// One read flag per cache line. Flags are set one at a time and cleared
// all together. Two independent probe ports (snoop and eviction).
// Assumes: one address equals one line; clear has priority over set.
module txn_rdset #(
    parameter int AW    = 6,
    parameter int LINES = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clear,
    input  logic [AW-1:0] probe_a,
    output logic          hit_a,
    input  logic [AW-1:0] probe_b,
    output logic          hit_b
);

    logic [LINES-1:0] flags;

    // Flag storage: bulk clear wins over a single-line set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (clear) begin
            flags <= '0;
        end else if (set_en) begin
            flags[set_idx] <= 1'b1;
        end
    end

    // Probe lookups for snoops and evictions.
    always_comb begin
        hit_a = flags[probe_a];
        hit_b = flags[probe_b];
    end

endmodule

// File: rtl/txn_wbuf.sv
// Module: txn_wbuf
// Speculative store buffer of DEPTH address/data entries, fully
// associative. Offers lookups for loads (with data), stores (hit/full)
// and snoops (hit only). Entries are allocated in order from slot 0 and
// released all at once.
// Assumes: no duplicate addresses (guaranteed by overwrite-on-hit),
// clear has priority over write.
module txn_wbuf #(
    parameter int DEPTH = 8,
    parameter int AW    = 6,
    parameter int DW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                clear,
    input  logic [AW-1:0]       ld_addr,
    output logic                ld_hit,
    output logic [DW-1:0]       ld_data,
    output logic                st_hit,
    output logic                full,
    input  logic [AW-1:0]       snp_addr,
    output logic                snp_hit,
    output logic [DEPTH-1:0]    ent_valid,
    output logic [DEPTH*AW-1:0] ent_addr,
    output logic [DEPTH*DW-1:0] ent_data
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [CW-1:0]    cnt;
    logic [IW-1:0]    alloc_idx;
    logic [DEPTH-1:0] ld_m, st_m, snp_m;
    logic             do_alloc;

    assign alloc_idx = cnt[IW-1:0];
    assign full      = (cnt == CW'(DEPTH));
    assign do_alloc  = wr_en && !clear && !st_hit && !full;

    // Per-entry storage, match lines and flat export.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic ent_we;
        assign ld_m[i]  = vld[i] && (addr_q[i] == ld_addr);
        assign st_m[i]  = vld[i] && (addr_q[i] == wr_addr);
        assign snp_m[i] = vld[i] && (addr_q[i] == snp_addr);
        assign ent_we   = wr_en && !clear &&
                          (st_m[i] || (do_alloc && (alloc_idx == IW'(i))));

        // Valid bit: set on allocation, dropped on bulk release.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                vld[i] <= 1'b0;
            end else if (do_alloc && (alloc_idx == IW'(i))) begin
                vld[i] <= 1'b1;
            end
        end

        // Payload: written on allocation or on overwrite of a match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end else if (ent_we) begin
                addr_q[i] <= wr_addr;
                data_q[i] <= wr_data;
            end
        end

        assign ent_addr[i*AW +: AW] = addr_q[i];
        assign ent_data[i*DW +: DW] = data_q[i];
    end

    assign ent_valid = vld;
    assign st_hit    = |st_m;
    assign snp_hit   = |snp_m;
    assign ld_hit    = |ld_m;

    // Occupancy counter: next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (do_alloc) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Forwarded load data: OR of the (at most one) matching entry.
    always_comb begin
        ld_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ld_m[i]) ld_data = ld_data | data_q[i];
        end
    end

endmodule

// File: rtl/txn_ctrl.sv
// Module: txn_ctrl
// Transaction sequencer: opens, commits and aborts transactions, picks
// the abort cause by fixed priority and produces the snapshot, restore
// and drain-timing pulses.
// Assumes: event inputs are raw (ungated); gating by the open state
// is done here.
module txn_ctrl #(
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_begin,
    input  logic [PCW-1:0] tx_fail_pc,
    input  logic           tx_commit,
    input  logic           tx_abort,
    input  logic           ev_rwrite,
    input  logic           ev_rread,
    input  logic           ev_evict,
    input  logic           ev_ovf,
    output logic           active,
    output logic           snap,
    output logic           aborted,
    output logic [2:0]     cause,
    output logic [PCW-1:0] redirect_pc,
    output logic           abort_now,
    output logic           commit_now,
    output logic           drain_q
);

    import txn_pkg::*;

    abort_cause_e sel;

    // Abort detection and cause priority for the current cycle.
    always_comb begin
        abort_now = active && (ev_rwrite || ev_rread || ev_evict ||
                               ev_ovf || tx_abort);
        commit_now = active && tx_commit && !abort_now;
        if (ev_rwrite)      sel = CAUSE_RWRITE;
        else if (ev_rread)  sel = CAUSE_RREAD;
        else if (ev_evict)  sel = CAUSE_EVICT;
        else if (ev_ovf)    sel = CAUSE_OVF;
        else                sel = CAUSE_SW;
    end

    // Transaction state, pulses and latched fail address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= 1'b0;
            snap        <= 1'b0;
            aborted     <= 1'b0;
            cause       <= CAUSE_NONE;
            redirect_pc <= '0;
            drain_q     <= 1'b0;
        end else begin
            snap    <= 1'b0;
            aborted <= 1'b0;
            drain_q <= commit_now;
            if (abort_now) begin
                active  <= 1'b0;
                aborted <= 1'b1;
                cause   <= sel;
            end else if (commit_now) begin
                active <= 1'b0;
            end else if (tx_begin && !active) begin
                active      <= 1'b1;
                snap        <= 1'b1;
                redirect_pc <= tx_fail_pc;
                cause       <= CAUSE_NONE;
            end
        end
    end

endmodule

// File: rtl/txn_spec_state.sv
// Module: txn_spec_state (top)
// Per-core speculative state for best-effort transactional memory:
// read flags per line, a store buffer with load forwarding, snoop
// conflict checks and a one-cycle wide commit drain.
// Assumes: one address is one line; the core issues no load or store in
// the commit cycle (such an access is dropped); the cache absorbs all
// drain slots in the cycle they are shown.
module txn_spec_state #(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int PCW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_begin,
    input  logic [PCW-1:0]      tx_fail_pc,
    input  logic                tx_commit,
    input  logic                tx_abort,
    input  logic                ld_valid,
    input  logic [AW-1:0]       ld_addr,
    input  logic [DW-1:0]       ld_cache_data,
    output logic [DW-1:0]       ld_data,
    input  logic                st_valid,
    input  logic [AW-1:0]       st_addr,
    input  logic [DW-1:0]       st_data,
    input  logic                snp_valid,
    input  logic                snp_is_write,
    input  logic [AW-1:0]       snp_addr,
    input  logic                evict_valid,
    input  logic [AW-1:0]       evict_addr,
    output logic                tx_active,
    output logic                ckpt_snap,
    output logic                tx_aborted,
    output logic [2:0]          abort_cause,
    output logic [PCW-1:0]      redirect_pc,
    output logic [DEPTH-1:0]    drain_valid,
    output logic [DEPTH*AW-1:0] drain_addr,
    output logic [DEPTH*DW-1:0] drain_data
);

    logic          abort_now, commit_now, drain_q;
    logic          rs_snp_hit, rs_ev_hit;
    logic          wb_ld_hit, wb_st_hit, wb_full, wb_snp_hit;
    logic [DW-1:0] wb_ld_data;
    logic [DEPTH-1:0] ent_valid;
    logic          ev_rwrite, ev_rread, ev_evict, ev_ovf;
    logic          rs_set, wb_wr, quiet;

    // Accesses are recorded only in an open, non-ending cycle.
    assign quiet  = tx_active && !abort_now && !tx_commit;
    assign rs_set = quiet && ld_valid;
    assign wb_wr  = quiet && st_valid;

    // Raw conflict and capacity events (gated by the sequencer).
    assign ev_rwrite = snp_valid && snp_is_write && (rs_snp_hit || wb_snp_hit);
    assign ev_rread  = snp_valid && !snp_is_write && wb_snp_hit;
    assign ev_evict  = evict_valid && rs_ev_hit;
    assign ev_ovf    = st_valid && wb_full && !wb_st_hit;

    txn_rdset #(.AW(AW)) u_rdset (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (rs_set),
        .set_idx (ld_addr),
        .clear   (abort_now || commit_now),
        .probe_a (snp_addr),
        .hit_a   (rs_snp_hit),
        .probe_b (evict_addr),
        .hit_b   (rs_ev_hit)
    );

    txn_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wb_wr),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .clear     (abort_now || drain_q),
        .ld_addr   (ld_addr),
        .ld_hit    (wb_ld_hit),
        .ld_data   (wb_ld_data),
        .st_hit    (wb_st_hit),
        .full      (wb_full),
        .snp_addr  (snp_addr),
        .snp_hit   (wb_snp_hit),
        .ent_valid (ent_valid),
        .ent_addr  (drain_addr),
        .ent_data  (drain_data)
    );

    txn_ctrl #(.PCW(PCW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_begin    (tx_begin),
        .tx_fail_pc  (tx_fail_pc),
        .tx_commit   (tx_commit),
        .tx_abort    (tx_abort),
        .ev_rwrite   (ev_rwrite),
        .ev_rread    (ev_rread),
        .ev_evict    (ev_evict),
        .ev_ovf      (ev_ovf),
        .active      (tx_active),
        .snap        (ckpt_snap),
        .aborted     (tx_aborted),
        .cause       (abort_cause),
        .redirect_pc (redirect_pc),
        .abort_now   (abort_now),
        .commit_now  (commit_now),
        .drain_q     (drain_q)
    );

    // Load result: buffered value wins over the cache copy.
    assign ld_data = wb_ld_hit ? wb_ld_data : ld_cache_data;

    // Drain enables: buffer contents shown in the cycle after commit.
    assign drain_valid = ent_valid & {DEPTH{drain_q}};

endmodule

// File: rtl/txn_spec_sva.sv
// Module: txn_spec_sva
// Property checker for txn_spec_state, attached by bind below.
// Assumes: observes top-level ports only.
module txn_spec_sva #(
    parameter int DEPTH = 8,
    parameter int PCW   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_active,
    input logic             ckpt_snap,
    input logic             tx_aborted,
    input logic [2:0]       abort_cause,
    input logic [PCW-1:0]   redirect_pc,
    input logic [DEPTH-1:0] drain_valid
);

    // R1: a transaction opening comes with a snapshot request.
    p_snap_on_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> ckpt_snap);

    // R1: a snapshot is only requested when leaving the idle state.
    p_snap_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_snap |-> (tx_active && !$past(tx_active)));

    // R10: an abort ends an open transaction.
    p_abort_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_aborted |-> ($past(tx_active) && !tx_active));

    // R10: the redirect target is not disturbed by the abort.
    p_redirect_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_aborted |-> $stable(redirect_pc));

    // R12: every abort reports a non-zero cause.
    p_abort_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_aborted |-> (abort_cause != 3'd0));

    // R9: the drain is shown for exactly one cycle.
    p_drain_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|drain_valid) |=> (drain_valid == '0));

    // R9: the drain follows the close of a transaction.
    p_drain_after_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|drain_valid) |-> (!tx_active && $past(tx_active)));

    // R11: an aborted transaction never drains.
    p_no_drain_on_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_aborted |-> (drain_valid == '0));

endmodule

bind txn_spec_state txn_spec_sva #(.DEPTH(DEPTH), .PCW(PCW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_active   (tx_active),
    .ckpt_snap   (ckpt_snap),
    .tx_aborted  (tx_aborted),
    .abort_cause (abort_cause),
    .redirect_pc (redirect_pc),
    .drain_valid (drain_valid)
);

// File: tb/txn_spec_state_test.sv
// Scoreboard bench: driver steps push expected output values tagged with
// the cycle they are due; a monitor at each falling edge compares them.
module txn_spec_state_test;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int PCW   = 16;

    localparam int S_ACT   = 0;
    localparam int S_SNAP  = 1;
    localparam int S_ABT   = 2;
    localparam int S_CAUSE = 3;
    localparam int S_PC    = 4;
    localparam int S_LD    = 5;
    localparam int S_DV    = 6;
    localparam int S_DA    = 7;
    localparam int S_DD    = 8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                tx_begin, tx_commit, tx_abort;
    logic [PCW-1:0]      tx_fail_pc;
    logic                ld_valid, st_valid, snp_valid, snp_is_write, evict_valid;
    logic [AW-1:0]       ld_addr, st_addr, snp_addr, evict_addr;
    logic [DW-1:0]       ld_cache_data, st_data, ld_data;
    logic                tx_active, ckpt_snap, tx_aborted;
    logic [2:0]          abort_cause;
    logic [PCW-1:0]      redirect_pc;
    logic [DEPTH-1:0]    drain_valid;
    logic [DEPTH*AW-1:0] drain_addr;
    logic [DEPTH*DW-1:0] drain_data;

    always #4 clk = ~clk;

    txn_spec_state #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .PCW(PCW)) uut (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_fail_pc(tx_fail_pc),
        .tx_commit(tx_commit), .tx_abort(tx_abort), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_cache_data(ld_cache_data), .ld_data(ld_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .snp_valid(snp_valid), .snp_is_write(snp_is_write), .snp_addr(snp_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .tx_active(tx_active), .ckpt_snap(ckpt_snap), .tx_aborted(tx_aborted),
        .abort_cause(abort_cause), .redirect_pc(redirect_pc),
        .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_data(drain_data)
    );

    typedef struct {
        int          at;
        int          sig;
        int          idx;
        logic [63:0] exp;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;

    function automatic logic [63:0] probe(int sig, int idx);
        case (sig)
            S_ACT:   return 64'(tx_active);
            S_SNAP:  return 64'(ckpt_snap);
            S_ABT:   return 64'(tx_aborted);
            S_CAUSE: return 64'(abort_cause);
            S_PC:    return 64'(redirect_pc);
            S_LD:    return 64'(ld_data);
            S_DV:    return 64'(drain_valid);
            S_DA:    return 64'(drain_addr[idx*AW +: AW]);
            S_DD:    return 64'(drain_data[idx*DW +: DW]);
            default: return 64'hDEAD;
        endcase
    endfunction

    task automatic expect_at(int d, int sig, int idx, logic [63:0] v, string req);
        exp_t e;
        e.at = cyc + d; e.sig = sig; e.idx = idx; e.exp = v; e.req = req;
        sbq.push_back(e);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                logic [63:0] act;
                act = probe(sbq[i].sig, sbq[i].idx);
                n_cmp = n_cmp + 1;
                if (act !== sbq[i].exp) begin
                    n_bad = n_bad + 1;
                    $display("FAIL %s sig=%0d idx=%0d actual=%h expected=%h (cycle %0d)",
                             sbq[i].req, sbq[i].sig, sbq[i].idx, act, sbq[i].exp, cyc);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic clear_all();
        tx_begin = 0; tx_commit = 0; tx_abort = 0; tx_fail_pc = '0;
        ld_valid = 0; ld_addr = '0; ld_cache_data = '0;
        st_valid = 0; st_addr = '0; st_data = '0;
        snp_valid = 0; snp_is_write = 0; snp_addr = '0;
        evict_valid = 0; evict_addr = '0;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        clear_all();
    endtask

    task automatic do_begin(logic [PCW-1:0] pc);
        step(); tx_begin = 1; tx_fail_pc = pc;
        expect_at(1, S_ACT, 0, 1, "R1 open");
    endtask

    task automatic do_load(logic [AW-1:0] a, logic [DW-1:0] cd, logic [DW-1:0] expv, string req);
        step(); ld_valid = 1; ld_addr = a; ld_cache_data = cd;
        expect_at(1, S_LD, 0, 64'(expv), req);
    endtask

    task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d);
        step(); st_valid = 1; st_addr = a; st_data = d;
    endtask

    task automatic expect_abort(int cause, string req);
        expect_at(1, S_ABT, 0, 1, req);
        expect_at(1, S_CAUSE, 0, 64'(cause), req);
        expect_at(1, S_ACT, 0, 0, req);
    endtask

    bit done = 0;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clear_all();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // Reset state (R12 cause, R9 drain).
        expect_at(1, S_ACT, 0, 0, "R1 reset idle");
        expect_at(1, S_CAUSE, 0, 0, "R12 reset cause");
        expect_at(1, S_DV, 0, 0, "R9 reset drain");
        expect_at(1, S_ABT, 0, 0, "R10 reset aborted");

        // R1: begin, snapshot, pc latch; second begin ignored.
        do_begin(16'h1234);
        expect_at(1, S_SNAP, 0, 1, "R1 snap pulse");
        expect_at(1, S_PC, 0, 16'h1234, "R1 pc latch");
        expect_at(2, S_SNAP, 0, 0, "R1 snap one cycle");
        step(); step(); tx_begin = 1; tx_fail_pc = 16'h5555;
        expect_at(1, S_SNAP, 0, 0, "R1 nested begin no snap");
        expect_at(1, S_PC, 0, 16'h1234, "R1 nested begin pc kept");
        expect_at(1, S_ACT, 0, 1, "R1 nested begin tx continues");

        // R3/R4: buffer, overwrite, forwarding.
        do_store(6'd5, 16'hAAAA);
        expect_at(1, S_DV, 0, 0, "R3 no drain before commit");
        do_store(6'd9, 16'hBBBB);
        do_store(6'd5, 16'hCCCC);
        do_load(6'd5, 16'h1111, 16'hCCCC, "R3 forward buffered value");
        do_load(6'd7, 16'h2222, 16'h2222, "R3 miss returns cache data");
        // R6: remote read on read-flagged line only: no effect.
        step(); snp_valid = 1; snp_is_write = 0; snp_addr = 6'd7;
        expect_at(1, S_ABT, 0, 0, "R6 remote read on read flag ignored");
        expect_at(1, S_ACT, 0, 1, "R6 tx still open");

        // R9: commit drain with overwrite in place (R4).
        step(); tx_commit = 1;
        expect_at(1, S_ACT, 0, 0, "R9 commit closes");
        expect_at(1, S_DV, 0, 8'b0000_0011, "R9 drain slots R4 no extra alloc");
        expect_at(1, S_DA, 0, 6'd5, "R9 slot0 addr");
        expect_at(1, S_DD, 0, 16'hCCCC, "R4 slot0 overwritten data");
        expect_at(1, S_DA, 1, 6'd9, "R9 slot1 addr");
        expect_at(1, S_DD, 1, 16'hBBBB, "R9 slot1 data");
        expect_at(2, S_DV, 0, 0, "R9 drain one cycle");
        step(); step();
        do_load(6'd5, 16'h3333, 16'h3333, "R9 buffer empty after commit");

        // R2/R5/R10: read flag, remote write conflict, redirect.
        do_begin(16'h0100);
        do_load(6'd3, 16'h0, 16'h0, "R2 load in tx");
        step(); snp_valid = 1; snp_is_write = 1; snp_addr = 6'd3;
        expect_abort(2, "R5 remote write on read flag R2");
        expect_at(1, S_PC, 0, 16'h0100, "R10 redirect pc");
        expect_at(2, S_ABT, 0, 0, "R10 abort pulse one cycle");
        expect_at(3, S_CAUSE, 0, 2, "R12 cause held");
        step(); step();

        // R10: read flags cleared; R6 remote read on buffer; R12 cause reset.
        do_begin(16'h0200);
        expect_at(1, S_CAUSE, 0, 0, "R12 cause reset on begin");
        step(); snp_valid = 1; snp_is_write = 1; snp_addr = 6'd3;
        expect_at(1, S_ABT, 0, 0, "R10 old read flag cleared");
        do_store(6'd10, 16'h7777);
        step(); snp_valid = 1; snp_is_write = 0; snp_addr = 6'd10;
        expect_abort(1, "R6 remote read on buffer");
        expect_at(1, S_DV, 0, 0, "R10 no drain on abort");
        do_load(6'd10, 16'h4444, 16'h4444, "R10 buffer discarded");

        // R5: remote write on buffered address.
        do_begin(16'h0300);
        do_store(6'd20, 16'h0001);
        step(); snp_valid = 1; snp_is_write = 1; snp_addr = 6'd20;
        expect_abort(2, "R5 remote write on buffer");

        // R7: eviction.
        do_begin(16'h0400);
        do_load(6'd30, 16'h0, 16'h0, "R2 load line 30");
        step(); evict_valid = 1; evict_addr = 6'd31;
        expect_at(1, S_ABT, 0, 0, "R7 unflagged eviction ignored");
        expect_at(1, S_ACT, 0, 1, "R7 tx still open");
        step(); evict_valid = 1; evict_addr = 6'd30;
        expect_abort(4, "R7 flagged eviction");

        // R4: fill, overwrite when full, overflow.
        do_begin(16'h0500);
        for (int k = 0; k < DEPTH; k++) do_store(6'(40 + k), 16'(k));
        do_store(6'd40, 16'h9999);
        expect_at(1, S_ABT, 0, 0, "R4 overwrite when full no abort");
        expect_at(1, S_ACT, 0, 1, "R4 tx open when full");
        do_store(6'd50, 16'h1);
        expect_abort(3, "R4 overflow");

        // R8: explicit abort.
        do_begin(16'h0600);
        step(); tx_abort = 1;
        expect_abort(5, "R8 explicit abort");

        // R11: remote read beats eviction and explicit.
        do_begin(16'h0700);
        do_load(6'd60, 16'h0, 16'h0, "R2 load line 60");
        do_store(6'd61, 16'h5);
        step(); snp_valid = 1; snp_is_write = 0; snp_addr = 6'd61;
        evict_valid = 1; evict_addr = 6'd60; tx_abort = 1;
        expect_abort(1, "R11 remote read over eviction");

        // R11: remote write beats eviction and explicit.
        do_begin(16'h0800);
        do_load(6'd60, 16'h0, 16'h0, "R2 load line 60 again");
        step(); snp_valid = 1; snp_is_write = 1; snp_addr = 6'd60;
        evict_valid = 1; evict_addr = 6'd60; tx_abort = 1;
        expect_abort(2, "R11 remote write first");

        // R11: eviction beats explicit.
        do_begin(16'h0900);
        do_load(6'd33, 16'h0, 16'h0, "R2 load line 33");
        step(); evict_valid = 1; evict_addr = 6'd33; tx_abort = 1;
        expect_abort(4, "R11 eviction over explicit");

        // R11: abort beats commit.
        do_begin(16'h0A00);
        do_store(6'd62, 16'h6);
        step(); tx_commit = 1; tx_abort = 1;
        expect_abort(5, "R11 abort over commit");
        expect_at(1, S_DV, 0, 0, "R11 no drain");
        expect_at(2, S_DV, 0, 0, "R11 no late drain");

        repeat (4) step();
        if (sbq.size() != 0) begin
            n_bad = n_bad + sbq.size();
            $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule